// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block turns the pulse train of a fan tachometer into a 16-bit speed reading. It counts pulses of a slow reference tick, given as a one-cycle enable, over a span of tach pulses whose length is chosen by a 2-bit field. A larger reading therefore means a slower fan. A stalled fan drives the count to full scale, and the reading then shows all ones. A comparator raises a flag when the reading is above a programmed limit, which means the fan is slower than the allowed minimum.

Counting can run freely. It can also be tied to the on-phase of the fan's drive signal. In that gated mode a window opens only after the drive has been high for a guard time. When the drive goes low, the window is dropped and the last reading is kept. Results reach the reading register in one of two ways. In periodic mode they are loaded when an interval timer expires, and the interval has three lengths. In opportunistic mode each result is loaded as soon as it completes, and the interval timer restarts at that moment.

Top module: `fan_tach_meter`

## Requirements
- R1: With the drive not gated, the reading equals the number of cycles with `tick_en` high between the first and the last rising tach edge of a window. A window spans N rising edges, so for a steady tach period it holds (N-1) periods' worth of ticks.
- R2: If the count reaches all ones before the window is complete, the result is all ones. This also holds when no tach edge arrives at all. After that result a new window starts.
- R3: `edge_sel` sets N: 00 selects 2 edges, 01 selects 3, 10 selects 5 and 11 selects 9.
- R4: With `gated_mode` high, the window is abandoned whenever `pwm_hi` is low. No result is produced and the reading is held. The count restarts from zero in the next on-phase, so a sequence of short on-phases never reaches the all-ones timeout.
- R5: With `gated_mode` high, tach edges count only after `pwm_hi` has stayed high for GUARD_TICKS reference ticks.
- R6: With `opp_mode` low, the reading changes only when the interval timer expires. It then takes the latest completed result. The interval is UPD_T0 ticks for `upd_sel`=00, UPD_T1 ticks for 01, and UPD_T2 ticks for 10 or 11.
- R7: With `opp_mode` high, every completed result is loaded into the reading on the next cycle, and the interval timer restarts from zero.
- R8: `below_min` is high exactly when `reading` is greater than `min_limit`. The comparison is unsigned.
- R9: While `rst_n` is low, `reading` is 0 and `below_min` is 0.
- R10: `tach_in` is asynchronous. It is passed through a two-flop synchronizer, and only its rising edges count, so the tach duty cycle does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| tick_en | input | 1 | One-cycle enable marking each reference tick |
| tach_in | input | 1 | Raw tachometer signal (asynchronous) |
| pwm_hi | input | 1 | Level of the associated fan drive output |
| gated_mode | input | 1 | 1: count only during the drive on-phase after the guard time |
| edge_sel | input | 2 | Edges per window (00:2, 01:3, 10:5, 11:9) |
| upd_sel | input | 2 | Update interval select (00:T0, 01:T1, 1x:T2) |
| opp_mode | input | 1 | 1: load each result at once and restart the interval |
| min_limit | input | CNT_W | Slowest allowed reading |
| reading | output | CNT_W | Measured tick count |
| below_min | output | 1 | Reading is above `min_limit` |

## Verification
A wrong window state shows up directly as a wrong reading value. A slip of one edge in the edge count changes the result by whole tach periods. A tick lost at a window boundary changes it by one. In opportunistic mode either error appears within one window; in periodic mode it appears at the next timer expiry. A guard counter that is too short, or a count that is not cleared when a window is abandoned, shows up as a reading that changes during short on-phases. It can also show up as a false all-ones value after roughly 65 536 accumulated ticks. An interval timer that is not restarted moves the instant at which a periodic update becomes visible, and the bench detects this within one interval.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_GUARD = 2'd1,
    W_WAIT  = 2'd2,
    W_COUNT = 2'd3
  } win_state_t;

  // edges per measurement window, selected by a 2-bit field
  function automatic logic [3:0] edges_for_sel(input logic [1:0] sel);
    logic [3:0] n;
    case (sel)
      2'b00:   n = 4'd2;
      2'b01:   n = 4'd3;
      2'b10:   n = 4'd5;
      default: n = 4'd9;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [SYNC_STAGES-1:0] sync_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = tach_in;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], tach_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // R10: only a rising edge of the synchronized level counts
  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/tach_window_fsm.sv
module tach_window_fsm
  import fan_tach_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int GUARD_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             rise,
  input  logic             gated_mode,
  input  logic             pwm_hi,
  input  logic [1:0]       edge_sel,
  output logic             done_o,
  output logic [CNT_W-1:0] val_o
);

  localparam int GW = (GUARD_TICKS < 2) ? 1 : $clog2(GUARD_TICKS);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [GW-1:0]    GUARD_END = GW'(GUARD_TICKS - 1);

  win_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [3:0]       edg_q, edg_d, need;
  logic [GW-1:0]    g_q, g_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic             abort;

  assign need    = edges_for_sel(edge_sel);
  assign cnt_inc = (tick_en && (cnt_q != CNT_MAX)) ? cnt_q + 1'b1 : cnt_q;
  assign abort   = gated_mode && !pwm_hi && (st_q != W_IDLE);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    edg_d  = edg_q;
    g_d    = g_q;
    done_d = 1'b0;
    val_d  = val_q;
    case (st_q)
      W_IDLE: begin
        if (!gated_mode) begin
          st_d  = W_WAIT;
          cnt_d = '0;
        end else if (pwm_hi) begin
          st_d = W_GUARD;
          g_d  = '0;
        end
      end
      W_GUARD: begin
        if (!gated_mode) begin
          st_d  = W_WAIT;
          cnt_d = '0;
        end else if (tick_en) begin
          if (g_q == GUARD_END) begin
            st_d  = W_WAIT;
            cnt_d = '0;
          end else begin
            g_d = g_q + 1'b1;
          end
        end
      end
      W_WAIT: begin
        if (rise) begin
          st_d  = W_COUNT;
          cnt_d = '0;
          edg_d = 4'd1;
        end else if (cnt_inc == CNT_MAX) begin
          done_d = 1'b1;
          val_d  = CNT_MAX;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        if (rise && ((edg_q + 4'd1) == need)) begin
          done_d = 1'b1;
          val_d  = cnt_inc;
          st_d   = W_WAIT;
          cnt_d  = '0;
        end else if (cnt_inc == CNT_MAX) begin
          done_d = 1'b1;
          val_d  = CNT_MAX;
          st_d   = W_WAIT;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_inc;
          if (rise) edg_d = edg_q + 4'd1;
        end
      end
    endcase
    if (abort) begin
      st_d   = W_IDLE;
      done_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      cnt_q  <= '0;
      edg_q  <= '0;
      g_q    <= '0;
      done_q <= 1'b0;
      val_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      edg_q  <= edg_d;
      g_q    <= g_d;
      done_q <= done_d;
      val_q  <= val_d;
    end
  end

  assign done_o = done_q;
  assign val_o  = val_q;

  // R2: a count one short of full scale plus a tick ends the window with all ones
  assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == W_WAIT || st_q == W_COUNT) && cnt_q == CNT_MAX - 1'b1 && tick_en
      && !rise && !abort)
    |=> (done_o && val_o == CNT_MAX));

  // R4: drive off in gated mode never yields a result
  assert_gated_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gated_mode && !pwm_hi) |=> !done_o);

  // R5: leaving the guard requires the full guard count
  assert_guard_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == W_WAIT && $past(st_q) == W_GUARD && $past(gated_mode))
    |-> ($past(g_q) == GUARD_END && $past(tick_en)));

endmodule

// File: rtl/tach_update_ctrl.sv
module tach_update_ctrl #(
  parameter int CNT_W  = 16,
  parameter int UPD_T0 = 27000,
  parameter int UPD_T1 = 45000,
  parameter int UPD_T2 = 90000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             done_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             opp_mode,
  input  logic [1:0]       upd_sel,
  output logic [CNT_W-1:0] reading_o
);

  localparam int TMAX01 = (UPD_T0 > UPD_T1) ? UPD_T0 : UPD_T1;
  localparam int TMAX   = (TMAX01 > UPD_T2) ? TMAX01 : UPD_T2;
  localparam int UPD_W  = $clog2(TMAX + 1);

  logic [UPD_W-1:0] t_q, t_d, per_last;
  logic [CNT_W-1:0] rd_q, rd_d, pend_q, pend_d;
  logic             pv_q, pv_d;
  logic             expire;

  always_comb begin
    case (upd_sel)
      2'b00:   per_last = UPD_W'(UPD_T0 - 1);
      2'b01:   per_last = UPD_W'(UPD_T1 - 1);
      default: per_last = UPD_W'(UPD_T2 - 1);
    endcase
  end

  assign expire = tick_en && (t_q >= per_last);

  always_comb begin
    t_d    = tick_en ? t_q + 1'b1 : t_q;
    rd_d   = rd_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    if (opp_mode && done_i) begin
      rd_d = val_i;
      t_d  = '0;
      pv_d = 1'b0;
    end else if (expire) begin
      t_d = '0;
      if (done_i) begin
        rd_d = val_i;
        pv_d = 1'b0;
      end else if (pv_q) begin
        rd_d = pend_q;
        pv_d = 1'b0;
      end
    end else if (done_i) begin
      pend_d = val_i;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      rd_q   <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      t_q    <= t_d;
      rd_q   <= rd_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign reading_o = rd_q;

  // R7: an immediate load follows every completed result in opportunistic mode
  assert_opp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opp_mode && done_i) |=> (reading_o == $past(val_i)));

  // R6: a reading change only coincides with a freshly restarted interval
  assert_update_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reading_o != $past(reading_o)) |-> (t_q == '0));

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
  parameter int CNT_W       = 16,
  parameter int GUARD_TICKS = 8,
  parameter int UPD_T0      = 27000,
  parameter int UPD_T1      = 45000,
  parameter int UPD_T2      = 90000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             tach_in,
  input  logic             pwm_hi,
  input  logic             gated_mode,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       upd_sel,
  input  logic             opp_mode,
  input  logic [CNT_W-1:0] min_limit,
  output logic [CNT_W-1:0] reading,
  output logic             below_min
);

  logic             rise;
  logic             done;
  logic [CNT_W-1:0] val;

  tach_sync_edge #(.SYNC_STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tach_in(tach_in),
    .rise_o (rise)
  );

  tach_window_fsm #(
    .CNT_W      (CNT_W),
    .GUARD_TICKS(GUARD_TICKS)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .rise      (rise),
    .gated_mode(gated_mode),
    .pwm_hi    (pwm_hi),
    .edge_sel  (edge_sel),
    .done_o    (done),
    .val_o     (val)
  );

  tach_update_ctrl #(
    .CNT_W (CNT_W),
    .UPD_T0(UPD_T0),
    .UPD_T1(UPD_T1),
    .UPD_T2(UPD_T2)
  ) u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .done_i   (done),
    .val_i    (val),
    .opp_mode (opp_mode),
    .upd_sel  (upd_sel),
    .reading_o(reading)
  );

  // R8: slow-fan flag
  assign below_min = (reading > min_limit);

endmodule

// File: tb/fan_tach_meter_tb.sv
`timescale 1ns/1ps
module fan_tach_meter_tb;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        tach_in;
  logic        pwm_hi;
  logic        gated_mode;
  logic [1:0]  edge_sel;
  logic [1:0]  upd_sel;
  logic        opp_mode;
  logic [15:0] min_limit;
  logic [15:0] reading;
  logic        below_min;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // stimulus generator controls
  int cyc = 0;
  int tick_div = 4;
  int tach_per = 40;
  int tach_hi = 20;
  bit tach_run = 1;
  bit pwm_gen = 0;
  bit pwm_lvl = 0;
  int pwm_per = 160;
  int pwm_w = 0;

  fan_tach_meter #(
    .CNT_W(16), .GUARD_TICKS(8), .UPD_T0(64), .UPD_T1(128), .UPD_T2(256)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tach_in(tach_in),
    .pwm_hi(pwm_hi), .gated_mode(gated_mode), .edge_sel(edge_sel),
    .upd_sel(upd_sel), .opp_mode(opp_mode), .min_limit(min_limit),
    .reading(reading), .below_min(below_min)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // inputs change on the falling edge only; tach rises fall on cyc%4==2
  initial begin
    tick_en = 1'b0;
    tach_in = 1'b0;
    pwm_hi  = 1'b0;
    forever begin
      @(negedge clk);
      cyc = cyc + 1;
      tick_en = ((cyc % tick_div) == 0);
      tach_in = tach_run && (((cyc + 2) % tach_per) < tach_hi);
      pwm_hi  = pwm_gen ? (((cyc + 2) % pwm_per) < pwm_w) : pwm_lvl;
    end
  end

  function automatic int edges_n(input logic [1:0] s);
    case (s)
      2'b00:   return 2;
      2'b01:   return 3;
      2'b10:   return 5;
      default: return 9;
    endcase
  endfunction

  function automatic int exp_count(input logic [1:0] s, input int per, input int div);
    return (edges_n(s) - 1) * (per / div);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    wait_n(5);
    rst_n = 1'b1;
  endtask

  task automatic chk_flag(input int exp_rd);
    min_limit = 16'(exp_rd - 1);
    #1 chk("R8 limit below reading", int'(below_min), 1);
    min_limit = 16'(exp_rd);
    #1 chk("R8 limit equal reading", int'(below_min), 0);
    min_limit = 16'(exp_rd + 1 + ($urandom % 50));
    #1 chk("R8 limit above reading", int'(below_min), 0);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd1234);
    rst_n = 1'b0;
    gated_mode = 1'b0;
    edge_sel = 2'b00;
    upd_sel = 2'b00;
    opp_mode = 1'b0;
    min_limit = 16'd0;
    wait_n(4);
    // R9: reset state
    chk("R9 reading in reset", int'(reading), 0);
    chk("R9 flag in reset", int'(below_min), 0);
    rst_n = 1'b1;

    // R6: periodic interval 00 (64 ticks = 256 cycles)
    tach_per = 40; tach_hi = 20;
    do_reset();
    wait_n(220);
    chk("R6 no update before interval 00", int'(reading), 0);
    wait_n(80);
    chk("R6 update at interval 00", int'(reading), exp_count(2'b00, 40, 4));
    // R6: interval 01 (128 ticks = 512 cycles)
    upd_sel = 2'b01;
    do_reset();
    wait_n(480);
    chk("R6 no update before interval 01", int'(reading), 0);
    wait_n(80);
    chk("R6 update at interval 01", int'(reading), exp_count(2'b00, 40, 4));

    // R1/R3/R10: every edge select, then random periods and duty
    opp_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      edge_sel = 2'(s);
      tach_per = 48; tach_hi = 24;
      wait_n(3000);
      chk("R3 edge select count", int'(reading), exp_count(2'(s), 48, 4));
    end
    for (int i = 0; i < 6; i++) begin
      int k;
      k = 6 + int'($urandom % 35);
      edge_sel = 2'($urandom % 4);
      tach_per = 4 * k;
      tach_hi = 1 + int'($urandom % (tach_per - 1));
      wait_n(3000);
      chk("R1 R10 random period and duty", int'(reading), exp_count(edge_sel, tach_per, 4));
      chk_flag(int'(reading));
    end

    // R7: interval restarts on each opportunistic load (T2 = 256 ticks)
    edge_sel = 2'b00; upd_sel = 2'b10;
    tach_per = 40; tach_hi = 20;
    wait_n(400);
    chk("R7 opportunistic value", int'(reading), 10);
    opp_mode = 1'b0;
    tach_per = 80; tach_hi = 40;
    wait_n(900);
    chk("R7 interval restarted by last load", int'(reading), 10);
    wait_n(200);
    chk("R6 R7 periodic load after restart", int'(reading), 20);

    // R5: guard time gates edges at the start of the on-phase
    opp_mode = 1'b1; gated_mode = 1'b1;
    tach_per = 40; tach_hi = 20;
    pwm_gen = 1'b1; pwm_per = 160; pwm_w = 60;
    wait_n(2000);
    chk("R5 short on-phase within guard gives no result", int'(reading), 20);
    pwm_w = 130;
    wait_n(1000);
    chk("R5 result after guard", int'(reading), 10);
    // R4: drive held low keeps the reading
    pwm_gen = 1'b0; pwm_lvl = 1'b0;
    tach_per = 60; tach_hi = 30;
    wait_n(1000);
    chk("R4 reading held with drive off", int'(reading), 10);

    // R4: no timeout from accumulated on-phases without tach
    tach_run = 1'b0; tick_div = 1;
    pwm_gen = 1'b1; pwm_per = 1000; pwm_w = 990;
    wait_n(68000);
    chk("R4 no timeout across on-phases", int'(reading), 10);

    // R2: stall without gating saturates
    pwm_gen = 1'b0; gated_mode = 1'b0;
    wait_n(65600);
    chk("R2 stalled fan reads full scale", int'(reading), 16'hFFFF);
    min_limit = 16'hFFFE;
    #1 chk("R8 full scale above limit", int'(below_min), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule